// File: doc/BRIEF.md
# Deductive Fault List Propagation Unit

This unit evaluates one logic gate for one test vector during deductive fault simulation. It produces two results: the fault-free output value of the gate, and the set of faults whose effect reaches the gate output. Each set is a bitmap over a fixed fault universe, where bit k stands for fault k.

The gate type is given by two inputs: a controlling value and an inversion flag. AND uses 0/0, NAND uses 0/1, OR uses 1/0 and NOR uses 1/1. A buffer is a one-input gate with controlling value 0 and inversion 0. An inverter is a one-input gate with controlling value 0 and inversion 1. An enable mask states which input slots take part in the evaluation. The caller supplies the fault indices of the output stuck-at-0 and stuck-at-1 faults. A drop mask removes faults that were already detected earlier in the simulation.

Each request is accepted on a single-cycle valid strobe. The result appears on registered outputs one cycle later. A small two-state controller sets when the result is presented. In state IDLE no result is shown. The transition ACCEPT (in_valid while IDLE) moves to PRESENT. The transition CHAIN (in_valid while PRESENT) stays in PRESENT with a fresh result. The transition RETIRE (no in_valid while PRESENT) returns to IDLE.

Top module: `dfp_gate_unit`

## Requirements
- R1: After reset, out_valid and out_list are 0. Each cycle with in_valid high makes out_valid high in the next cycle, together with that request's result. A cycle without in_valid makes out_valid low in the next cycle.
- R2: If any enabled input equals ctrl_val, out_val is ctrl_val XOR inv_flag. Otherwise out_val is NOT(ctrl_val XOR inv_flag).
- R3: If no enabled input holds ctrl_val, out_list is the OR of all enabled input lists, plus the output fault stuck at (ctrl_val XOR inv_flag). For stuck-at-0 that fault is bit sa0_idx; for stuck-at-1 it is bit sa1_idx.
- R4: If at least one enabled input holds ctrl_val, out_list is the AND of the lists of those inputs, with the OR of the lists of the other enabled inputs removed. The output fault stuck at NOT(ctrl_val XOR inv_flag) is then added.
- R5: An input whose in_en bit is 0 affects neither out_val nor out_list, whatever its value and list.
- R6: A single enabled input with ctrl_val 0 yields that input's list plus the output fault stuck at the opposite of out_val. With inv_flag 0 this behaves as a buffer; with inv_flag 1 it behaves as an inverter.
- R7: Every bit set in drop_mask is 0 in out_list. This also applies to the output fault bit that the rules add.
- R8: While no in_valid arrives, out_val and out_list keep their last values.
- R9: Requests on consecutive cycles each produce their own result on consecutive cycles, in order.
- Input list j occupies bits [j*NFAULT +: NFAULT] of in_lists. Input value j is bit j of in_vals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_vals | input | NUM_IN | Fault-free input values |
| in_en | input | NUM_IN | Input slot enables |
| in_lists | input | NUM_IN*NFAULT | Packed input fault lists |
| ctrl_val | input | 1 | Controlling value of the gate type |
| inv_flag | input | 1 | Output inversion of the gate type |
| sa0_idx | input | IDX_W | Fault index of output stuck-at-0 |
| sa1_idx | input | IDX_W | Fault index of output stuck-at-1 |
| drop_mask | input | NFAULT | Already detected faults to remove |
| out_valid | output | 1 | Result valid |
| out_val | output | 1 | Fault-free gate output |
| out_list | output | NFAULT | Output fault list |

## Verification
Two functions can act on the same bit in the same cycle: the rules add the output fault bit, and the drop mask may clear that same bit. The bench provokes this by putting the selected output fault index into the drop mask. It then expects that bit to be absent while the merged list bits outside the mask survive. The second overlap is a new request arriving in the cycle a result is being shown. Three requests are driven back to back, and the scoreboard must see three distinct results in order, with out_valid never falling between them.

// File: rtl/dfp_pkg.sv
package dfp_pkg;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } dfp_state_e;
endpackage

// File: rtl/dfp_ctrl_scan.sv
module dfp_ctrl_scan #(
    parameter int NUM_IN = 3
) (
    input  logic [NUM_IN-1:0] in_vals,
    input  logic [NUM_IN-1:0] in_en,
    input  logic              ctrl_val,
    input  logic              inv_flag,
    output logic [NUM_IN-1:0] ctrl_hit,
    output logic              any_ctrl,
    output logic              gate_val
);
    // Inputs holding the controlling value, restricted to enabled slots
    for (genvar j = 0; j < NUM_IN; j++) begin : g_hit
        assign ctrl_hit[j] = in_en[j] & (in_vals[j] == ctrl_val);
    end

    assign any_ctrl = |ctrl_hit;
    assign gate_val = any_ctrl ? (ctrl_val ^ inv_flag) : ~(ctrl_val ^ inv_flag);
endmodule

// File: rtl/dfp_set_merge.sv
module dfp_set_merge #(
    parameter int NUM_IN = 3,
    parameter int NFAULT = 16
) (
    input  logic [NUM_IN*NFAULT-1:0] in_lists,
    input  logic [NUM_IN-1:0]        in_en,
    input  logic [NUM_IN-1:0]        ctrl_hit,
    input  logic                     any_ctrl,
    output logic [NFAULT-1:0]        merged
);
    logic [NFAULT-1:0] union_all;
    logic [NFAULT-1:0] inter_ctrl;
    logic [NFAULT-1:0] union_rest;

    always_comb begin
        union_all  = '0;
        inter_ctrl = '1;
        union_rest = '0;
        for (int j = 0; j < NUM_IN; j++) begin
            if (in_en[j]) begin
                union_all = union_all | in_lists[j*NFAULT +: NFAULT];
                if (ctrl_hit[j]) begin
                    inter_ctrl = inter_ctrl & in_lists[j*NFAULT +: NFAULT];
                end else begin
                    union_rest = union_rest | in_lists[j*NFAULT +: NFAULT];
                end
            end
        end
    end

    assign merged = any_ctrl ? (inter_ctrl & ~union_rest) : union_all;
endmodule

// File: rtl/dfp_fault_insert.sv
module dfp_fault_insert #(
    parameter int NFAULT = 16,
    localparam int IDX_W = (NFAULT > 1) ? $clog2(NFAULT) : 1
) (
    input  logic [NFAULT-1:0] merged,
    input  logic              sa_pol,
    input  logic [IDX_W-1:0]  sa0_idx,
    input  logic [IDX_W-1:0]  sa1_idx,
    input  logic [NFAULT-1:0] drop_mask,
    output logic [NFAULT-1:0] final_list
);
    logic [IDX_W-1:0] sel_idx;
    assign sel_idx = sa_pol ? sa1_idx : sa0_idx;

    for (genvar k = 0; k < NFAULT; k++) begin : g_bit
        assign final_list[k] = (merged[k] | (sel_idx == IDX_W'(k))) & ~drop_mask[k];
    end
endmodule

// File: rtl/dfp_gate_unit.sv
module dfp_gate_unit #(
    parameter int NUM_IN = 3,
    parameter int NFAULT = 16,
    localparam int IDX_W = (NFAULT > 1) ? $clog2(NFAULT) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [NUM_IN-1:0]        in_vals,
    input  logic [NUM_IN-1:0]        in_en,
    input  logic [NUM_IN*NFAULT-1:0] in_lists,
    input  logic                     ctrl_val,
    input  logic                     inv_flag,
    input  logic [IDX_W-1:0]         sa0_idx,
    input  logic [IDX_W-1:0]         sa1_idx,
    input  logic [NFAULT-1:0]        drop_mask,
    output logic                     out_valid,
    output logic                     out_val,
    output logic [NFAULT-1:0]        out_list
);
    import dfp_pkg::*;

    logic [NUM_IN-1:0] ctrl_hit;
    logic              any_ctrl;
    logic              gate_val;
    logic [NFAULT-1:0] merged;
    logic [NFAULT-1:0] final_list;

    dfp_state_e state_q, state_d;

    dfp_ctrl_scan #(.NUM_IN(NUM_IN)) u_scan (
        .in_vals  (in_vals),
        .in_en    (in_en),
        .ctrl_val (ctrl_val),
        .inv_flag (inv_flag),
        .ctrl_hit (ctrl_hit),
        .any_ctrl (any_ctrl),
        .gate_val (gate_val)
    );

    dfp_set_merge #(.NUM_IN(NUM_IN), .NFAULT(NFAULT)) u_merge (
        .in_lists (in_lists),
        .in_en    (in_en),
        .ctrl_hit (ctrl_hit),
        .any_ctrl (any_ctrl),
        .merged   (merged)
    );

    // The fault added at the output is stuck at the opposite of the good value
    dfp_fault_insert #(.NFAULT(NFAULT)) u_insert (
        .merged     (merged),
        .sa_pol     (~gate_val),
        .sa0_idx    (sa0_idx),
        .sa1_idx    (sa1_idx),
        .drop_mask  (drop_mask),
        .final_list (final_list)
    );

    // Next-state selection: ACCEPT, CHAIN, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (in_valid)  state_d = ST_PRESENT;
            ST_PRESENT: if (!in_valid) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result registers, loaded on every accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_val  <= 1'b0;
            out_list <= '0;
        end else if (in_valid) begin
            out_val  <= gate_val;
            out_list <= final_list;
        end
    end

    assign out_valid = (state_q == ST_PRESENT);
endmodule

// File: rtl/dfp_gate_unit_chk.sv
module dfp_gate_unit_chk #(
    parameter int NUM_IN = 3,
    parameter int NFAULT = 16,
    localparam int IDX_W = (NFAULT > 1) ? $clog2(NFAULT) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [IDX_W-1:0]  sa0_idx,
    input logic [IDX_W-1:0]  sa1_idx,
    input logic [NFAULT-1:0] drop_mask,
    input logic              out_valid,
    input logic              out_val,
    input logic [NFAULT-1:0] out_list
);
    p_valid_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_drop_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_list & $past(drop_mask)) == '0));

    // R3/R4: the output fault opposite to the good value is present unless dropped
    p_out_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_val
            ? ((32'($past(sa0_idx)) >= NFAULT) || out_list[$past(sa0_idx)] || $past(drop_mask[sa0_idx]))
            : ((32'($past(sa1_idx)) >= NFAULT) || out_list[$past(sa1_idx)] || $past(drop_mask[sa1_idx]))));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_list) && $stable(out_val)));
endmodule

bind dfp_gate_unit dfp_gate_unit_chk #(.NUM_IN(NUM_IN), .NFAULT(NFAULT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .sa0_idx   (sa0_idx),
    .sa1_idx   (sa1_idx),
    .drop_mask (drop_mask),
    .out_valid (out_valid),
    .out_val   (out_val),
    .out_list  (out_list)
);

// File: tb/dfp_gate_unit_test.sv
`timescale 1ns/1ps
module dfp_gate_unit_test;
    localparam int NI = 3;
    localparam int NF = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [NI-1:0] in_vals = '0;
    logic [NI-1:0] in_en = '0;
    logic [NI*NF-1:0] in_lists = '0;
    logic          ctrl_val = 1'b0;
    logic          inv_flag = 1'b0;
    logic [IW-1:0] sa0_idx = '0;
    logic [IW-1:0] sa1_idx = '0;
    logic [NF-1:0] drop_mask = '0;
    logic          out_valid;
    logic          out_val;
    logic [NF-1:0] out_list;

    always #4 clk = ~clk;

    dfp_gate_unit #(.NUM_IN(NI), .NFAULT(NF)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vals(in_vals),
        .in_en(in_en), .in_lists(in_lists), .ctrl_val(ctrl_val),
        .inv_flag(inv_flag), .sa0_idx(sa0_idx), .sa1_idx(sa1_idx),
        .drop_mask(drop_mask), .out_valid(out_valid), .out_val(out_val),
        .out_list(out_list)
    );

    typedef struct packed {
        logic          val;
        logic [NF-1:0] list;
        logic [7:0]    req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    logic done   = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model of the set rules
    function automatic exp_t model(input logic [NI-1:0] v, input logic [NI-1:0] en,
                                   input logic [NI*NF-1:0] ls, input logic c, input logic i,
                                   input logic [IW-1:0] s0, input logic [IW-1:0] s1,
                                   input logic [NF-1:0] dm, input logic [7:0] req);
        exp_t r;
        logic hit = 1'b0;
        logic [NF-1:0] u = '0, x = '1, o = '0;
        for (int j = 0; j < NI; j++) begin
            if (en[j]) begin
                u = u | ls[j*NF +: NF];
                if (v[j] == c) begin hit = 1'b1; x = x & ls[j*NF +: NF]; end
                else o = o | ls[j*NF +: NF];
            end
        end
        r.val  = hit ? (c ^ i) : !(c ^ i);
        r.list = hit ? (x & ~o) : u;
        if (r.val) r.list[s0] = 1'b1; else r.list[s1] = 1'b1;
        r.list = r.list & ~dm;
        r.req  = req;
        return r;
    endfunction

    task automatic send(input logic [NI-1:0] v, input logic [NI-1:0] en,
                        input logic [NI*NF-1:0] ls, input logic c, input logic i,
                        input logic [IW-1:0] s0, input logic [IW-1:0] s1,
                        input logic [NF-1:0] dm, input logic [7:0] req);
        @(negedge clk);
        in_valid = 1'b1; in_vals = v; in_en = en; in_lists = ls;
        ctrl_val = c; inv_flag = i; sa0_idx = s0; sa1_idx = s1; drop_mask = dm;
        exp_q.push_back(model(v, en, ls, c, i, s0, s1, dm, req));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare each presented result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected out_valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                string tag;
                e = exp_q.pop_front();
                tag = $sformatf("R%0d", e.req);
                check({tag, " out_val"}, 32'(out_val), 32'(e.val));
                check({tag, " out_list"}, 32'(out_list), 32'(e.list));
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [NF-1:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", 32'(out_valid), 32'd0);
        check("R1 reset out_list", 32'(out_list), 32'd0);
        rst_n = 1'b1;
        idle(1);

        // R3: AND with both inputs at 1
        send(3'b011, 3'b011, {16'h0000, 16'h0030, 16'h0005}, 1'b0, 1'b0, 4'd10, 4'd11, '0, 8'd3);
        idle(2);
        // R4: AND with A=0, B=1
        send(3'b010, 3'b011, {16'h0000, 16'h0030, 16'h00F0}, 1'b0, 1'b0, 4'd10, 4'd11, '0, 8'd4);
        idle(2);
        // R2/R4: NAND with two controlling inputs, one non-controlling
        send(3'b100, 3'b111, {16'h0300, 16'h0F0F, 16'h0FF0}, 1'b0, 1'b1, 4'd12, 4'd13, '0, 8'd2);
        idle(2);
        // R3: NOR with no input at 1
        send(3'b000, 3'b111, {16'h1000, 16'h0200, 16'h0001}, 1'b1, 1'b1, 4'd14, 4'd15, '0, 8'd3);
        idle(2);
        // R6: buffer with input 1, then inverter with input 0
        send(3'b001, 3'b001, {16'hFFFF, 16'hFFFF, 16'h0042}, 1'b0, 1'b0, 4'd4, 4'd5, '0, 8'd6);
        idle(2);
        send(3'b110, 3'b001, {16'hFFFF, 16'hFFFF, 16'h0042}, 1'b0, 1'b1, 4'd4, 4'd5, '0, 8'd6);
        idle(2);
        // R5: disabled input holds the controlling value and a full list
        send(3'b011, 3'b011, {16'hFFFF, 16'h0100, 16'h0002}, 1'b0, 1'b0, 4'd8, 4'd9, '0, 8'd5);
        idle(2);
        // R7: drop mask removes the added output fault and part of the list
        send(3'b011, 3'b011, {16'h0000, 16'h0030, 16'h0005}, 1'b0, 1'b0, 4'd10, 4'd11,
             16'h0410, 8'd7);
        idle(2);
        // R9: three requests back to back
        send(3'b000, 3'b011, {16'h0000, 16'h00AA, 16'h0055}, 1'b1, 1'b0, 4'd0, 4'd1, '0, 8'd9);
        send(3'b001, 3'b011, {16'h0000, 16'h00AA, 16'h00FF}, 1'b1, 1'b0, 4'd2, 4'd3, '0, 8'd9);
        send(3'b011, 3'b011, {16'h0000, 16'h0F00, 16'h0FF0}, 1'b1, 1'b1, 4'd6, 4'd7, '0, 8'd9);
        idle(1);
        // R8: outputs hold while inputs change without in_valid
        held = out_list;
        in_lists = '1; in_vals = '1; in_en = '1; drop_mask = '0;
        idle(3);
        check("R8 hold out_list", 32'(out_list), 32'(held));
        check("R1 idle out_valid", 32'(out_valid), 32'd0);
        check("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule